// File: doc/BRIEF.md
# IPv4 Forwarding Fast Path

This block sits between the receive and transmit sides of a small four-port router. Ethernet frames arrive one byte per cycle, with a start marker on the first byte, an end marker on the last byte, and the number of the port the frame came in on. Each frame is held in a local frame store. At the end of the frame the block checks the Ethernet and IPv4 headers. It looks up the destination address in a routing table. It then looks up the resulting next-hop address in an address-resolution cache. When every step succeeds, the frame goes out on the forward stream. Its TTL is lowered by one, its header checksum is updated, and its MAC addresses are rewritten.

A frame that fails any check or misses either lookup is not dropped. It goes out unchanged on the slow-path stream, tagged with its input port, so control software can handle it. Control software fills both tables and the per-port source MAC addresses through a write-only configuration port.

Top module: `ipv4_fastpath`

## Requirements
- R1: A frame that passes every check and hits both lookups leaves on the forward stream with the same length. Its TTL (byte 22) is one lower and its checksum (bytes 24-25) equals a full recomputation over the rewritten 20-byte header. All other bytes from offset 12 on are unchanged.
- R2: A frame whose EtherType (bytes 12-13) is 0x0806 always leaves unchanged on the slow-path stream.
- R3: A frame leaves unchanged on the slow-path stream if any of these checks fails: at least 34 bytes long, EtherType 0x0800, byte 14 equal to 0x45 (version 4, five-word header), total length (bytes 16-17) plus 14 equal to the frame byte count, header checksum over bytes 14-33 correct.
- R4: A frame arriving with TTL 0 or 1 is punted unchanged. A frame arriving with TTL 2 may be forwarded.
- R5: Among valid routes where (destination AND mask) equals the prefix, the route whose mask has the most one bits wins. On a tie, the lower index wins.
- R6: A route with next hop 0.0.0.0 marks a directly attached destination. The cache is then searched with the destination address itself; otherwise it is searched with the route's next hop.
- R7: A routing miss or a cache miss sends the frame unchanged to the slow-path stream. The slow-path port field carries the frame's input port.
- R8: On forward, bytes 0-5 carry the cache's MAC address and bytes 6-11 carry the configured MAC of the output port. The forward port field equals the winning route's port and stays constant through the frame.
- R9: A configuration write stores cfgData into the register selected by cfgAddr[5:3], with cfgAddr[2:0] as the entry index:
  - 0: route prefix
  - 1: route mask
  - 2: route next hop
  - 3: route control, with valid in bit 2 and port in bits 1:0
  - 4: cache key, with valid in bit 32 and address in bits 31:0
  - 5: cache MAC in bits 47:0
  - 6: port MAC
  
  Clearing a valid bit removes that entry from the lookup.
- R10: The first byte of a frame's output appears no more than 16 cycles after its last input byte.
- R11: The two output streams are never valid in the same cycle. Both are idle after reset.
- R12: Frames leave in arrival order as contiguous bursts. The start marker is on the first byte and the end marker is on the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low synchronous reset |
| inValid | input | 1 | input byte valid |
| inSof | input | 1 | first byte of frame |
| inEof | input | 1 | last byte of frame |
| inData | input | 8 | input byte |
| inPort | input | 2 | port the frame arrived on |
| cfgWe | input | 1 | configuration write strobe |
| cfgAddr | input | 6 | configuration register select and index |
| cfgData | input | 48 | configuration write data |
| fwdValid | output | 1 | forward byte valid |
| fwdSof | output | 1 | forward first byte |
| fwdEof | output | 1 | forward last byte |
| fwdData | output | 8 | forward byte |
| fwdPort | output | 2 | output port of forwarded frame |
| slowValid | output | 1 | slow-path byte valid |
| slowSof | output | 1 | slow-path first byte |
| slowEof | output | 1 | slow-path last byte |
| slowData | output | 8 | slow-path byte |
| slowPort | output | 2 | input port of punted frame |

## Verification
The assertions rely on three assumptions about the input:
- The sender sends each frame as a contiguous burst of no more than 64 bytes.
- The sender waits until a frame has fully left before it starts the next one, so no input byte arrives while either output stream is active.
- The configuration is written only while no frame is in flight.

The stimulus keeps to all three: it writes the tables before traffic, or between frames while the block is idle. It sends 40-byte or shorter frames one at a time, then idles for longer than the frame takes to drain.

// File: rtl/fp_pkg.sv
package fp_pkg;
  localparam int IDX_W = 7;

  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] capIdx;
    logic             decide;
    logic             emit;
    logic [IDX_W-1:0] emitIdx;
    logic             emitFirst;
    logic             emitLast;
  } fp_strobe_t;

  function automatic logic [15:0] ocAdd(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction
endpackage

// File: rtl/fp_tables.sv
module fp_tables #(
  parameter int ROUTES = 8,
  parameter int ARPS   = 8,
  parameter int PORTS  = 4,
  localparam int PW    = $clog2(PORTS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic [5:0]    cfgAddr,
  input  logic [47:0]   cfgData,
  input  logic [31:0]   dstIp,
  output logic          routeHit,
  output logic [PW-1:0] routePort,
  output logic          arpHit,
  output logic [47:0]   arpMac,
  output logic [47:0]   portMac
);
  logic [31:0]   rtPrefix [ROUTES];
  logic [31:0]   rtMask   [ROUTES];
  logic [31:0]   rtNh     [ROUTES];
  logic [PW-1:0] rtPort   [ROUTES];
  logic          rtValid  [ROUTES];
  logic [31:0]   arpKey   [ARPS];
  logic [47:0]   arpVal   [ARPS];
  logic          arpValid [ARPS];
  logic [47:0]   pMac     [PORTS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ROUTES; i++) begin
        rtPrefix[i] <= '0; rtMask[i] <= '0; rtNh[i] <= '0;
        rtPort[i] <= '0; rtValid[i] <= 1'b0;
      end
      for (int i = 0; i < ARPS; i++) begin
        arpKey[i] <= '0; arpVal[i] <= '0; arpValid[i] <= 1'b0;
      end
      for (int i = 0; i < PORTS; i++) pMac[i] <= '0;
    end else if (cfgWe) begin
      for (int i = 0; i < ROUTES; i++) begin
        if (int'(cfgAddr[2:0]) == i) begin
          case (cfgAddr[5:3])
            3'd0: rtPrefix[i] <= cfgData[31:0];
            3'd1: rtMask[i]   <= cfgData[31:0];
            3'd2: rtNh[i]     <= cfgData[31:0];
            3'd3: begin rtPort[i] <= cfgData[PW-1:0]; rtValid[i] <= cfgData[2]; end
            default: ;
          endcase
        end
      end
      for (int i = 0; i < ARPS; i++) begin
        if (int'(cfgAddr[2:0]) == i) begin
          if (cfgAddr[5:3] == 3'd4) begin arpKey[i] <= cfgData[31:0]; arpValid[i] <= cfgData[32]; end
          if (cfgAddr[5:3] == 3'd5) arpVal[i] <= cfgData;
        end
      end
      for (int i = 0; i < PORTS; i++)
        if (cfgAddr[5:3] == 3'd6 && int'(cfgAddr[2:0]) == i) pMac[i] <= cfgData;
    end
  end

  int bestLen;
  int mLen;
  logic [31:0] bestNh;
  logic [31:0] arpQuery;

  always_comb begin
    routeHit  = 1'b0;
    routePort = '0;
    bestNh    = '0;
    bestLen   = 0;
    mLen      = 0;
    for (int i = 0; i < ROUTES; i++) begin
      mLen = $countones(rtMask[i]);
      if (rtValid[i] && ((dstIp & rtMask[i]) == rtPrefix[i]) && (!routeHit || mLen > bestLen)) begin
        routeHit  = 1'b1;
        routePort = rtPort[i];
        bestNh    = rtNh[i];
        bestLen   = mLen;
      end
    end
  end

  assign arpQuery = (bestNh == 32'd0) ? dstIp : bestNh;

  always_comb begin
    arpHit = 1'b0;
    arpMac = '0;
    for (int i = ARPS - 1; i >= 0; i--) begin
      if (arpValid[i] && arpKey[i] == arpQuery) begin
        arpHit = 1'b1;
        arpMac = arpVal[i];
      end
    end
  end

  assign portMac = pMac[routePort];
endmodule

// File: rtl/fp_control.sv
module fp_control
  import fp_pkg::*;
#(
  parameter int MAX_BYTES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEof,
  output fp_strobe_t       st,
  output logic [IDX_W-1:0] frameLen
);
  typedef enum logic [1:0] {S_IDLE, S_RECV, S_LOOK, S_EMIT} state_t;
  state_t state;
  logic [IDX_W-1:0] wrCnt;
  logic [IDX_W-1:0] rdCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      wrCnt <= '0;
      rdCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (inValid && inSof) begin
          wrCnt <= IDX_W'(1);
          state <= inEof ? S_LOOK : S_RECV;
        end
        S_RECV: if (inValid) begin
          if (wrCnt < IDX_W'(MAX_BYTES)) wrCnt <= wrCnt + 1'b1;
          if (inEof) state <= S_LOOK;
        end
        S_LOOK: begin
          rdCnt <= '0;
          state <= S_EMIT;
        end
        S_EMIT: begin
          rdCnt <= rdCnt + 1'b1;
          if (rdCnt == wrCnt - IDX_W'(1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    st.capture   = inValid && ((state == S_IDLE && inSof) || state == S_RECV);
    st.capIdx    = (state == S_IDLE) ? '0 : wrCnt;
    st.decide    = (state == S_LOOK);
    st.emit      = (state == S_EMIT);
    st.emitIdx   = rdCnt;
    st.emitFirst = (rdCnt == '0);
    st.emitLast  = (rdCnt == wrCnt - IDX_W'(1));
  end

  assign frameLen = wrCnt;
endmodule

// File: rtl/fp_datapath.sv
module fp_datapath
  import fp_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int PW        = 2,
  localparam int AW       = $clog2(MAX_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fp_strobe_t       st,
  input  logic [7:0]       inData,
  input  logic [PW-1:0]    inPort,
  input  logic [IDX_W-1:0] frameLen,
  output logic [31:0]      dstIp,
  input  logic             routeHit,
  input  logic [PW-1:0]    routePort,
  input  logic             arpHit,
  input  logic [47:0]      arpMac,
  input  logic [47:0]      portMac,
  output logic             fwdValid,
  output logic             fwdSof,
  output logic             fwdEof,
  output logic [7:0]       fwdData,
  output logic [PW-1:0]    fwdPort,
  output logic             slowValid,
  output logic             slowSof,
  output logic             slowEof,
  output logic [7:0]       slowData,
  output logic [PW-1:0]    slowPort
);
  logic [7:0] frameMem [MAX_BYTES];

  always_ff @(posedge clk)
    if (st.capture && st.capIdx < IDX_W'(MAX_BYTES)) frameMem[st.capIdx[AW-1:0]] <= inData;

  logic [15:0] etherType, totLen, hdrCs, hdrSum, newCs;
  logic [7:0]  verIhl, ttl, proto;
  logic        lenOk, canFwd;

  always_comb begin
    etherType = {frameMem[12], frameMem[13]};
    verIhl    = frameMem[14];
    totLen    = {frameMem[16], frameMem[17]};
    ttl       = frameMem[22];
    proto     = frameMem[23];
    hdrCs     = {frameMem[24], frameMem[25]};
    dstIp     = {frameMem[30], frameMem[31], frameMem[32], frameMem[33]};
    hdrSum    = '0;
    for (int w = 0; w < 10; w++) hdrSum = ocAdd(hdrSum, {frameMem[14 + 2*w], frameMem[15 + 2*w]});
    lenOk  = (frameLen >= IDX_W'(34)) && (({1'b0, totLen} + 17'd14) == {{(17-IDX_W){1'b0}}, frameLen});
    canFwd = lenOk && etherType == 16'h0800 && verIhl == 8'h45 && hdrSum == 16'hFFFF &&
             ttl > 8'd1 && routeHit && arpHit;
    newCs  = ~ocAdd(ocAdd(~hdrCs, ~{ttl, proto}), {ttl - 8'd1, proto});
  end

  logic          dFwd;
  logic [PW-1:0] dPort, srcPort;
  logic [47:0]   dDmac, dSmac;
  logic [7:0]    dTtl;
  logic [15:0]   dCs;
  logic [7:0]    outByte;
  logic [7:0]    emitByte;
  int            k;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dFwd <= 1'b0; dPort <= '0; srcPort <= '0;
      dDmac <= '0; dSmac <= '0; dTtl <= '0; dCs <= '0;
    end else begin
      if (st.capture && st.capIdx == '0) srcPort <= inPort;
      if (st.decide) begin
        dFwd  <= canFwd;
        dPort <= routePort;
        dDmac <= arpMac;
        dSmac <= portMac;
        dTtl  <= ttl - 8'd1;
        dCs   <= newCs;
      end
    end
  end

  always_comb begin
    k = int'(st.emitIdx);
    emitByte = (k < MAX_BYTES) ? frameMem[st.emitIdx[AW-1:0]] : 8'h00;
    if (dFwd) begin
      if (k < 6)                 emitByte = dDmac[47 - 8*k -: 8];
      else if (k < 12)           emitByte = dSmac[47 - 8*(k-6) -: 8];
      else if (k == 22)          emitByte = dTtl;
      else if (k == 24)          emitByte = dCs[15:8];
      else if (k == 25)          emitByte = dCs[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdValid <= 1'b0; slowValid <= 1'b0;
      fwdSof <= 1'b0; fwdEof <= 1'b0; slowSof <= 1'b0; slowEof <= 1'b0;
      outByte <= '0;
    end else begin
      fwdValid  <= st.emit && dFwd;
      slowValid <= st.emit && !dFwd;
      fwdSof    <= st.emit && dFwd && st.emitFirst;
      fwdEof    <= st.emit && dFwd && st.emitLast;
      slowSof   <= st.emit && !dFwd && st.emitFirst;
      slowEof   <= st.emit && !dFwd && st.emitLast;
      if (st.emit) outByte <= emitByte;
    end
  end

  assign fwdData  = outByte;
  assign slowData = outByte;
  assign fwdPort  = dPort;
  assign slowPort = srcPort;
endmodule

// File: rtl/ipv4_fastpath.sv
module ipv4_fastpath
  import fp_pkg::*;
#(
  parameter int MAX_BYTES = 64,
  parameter int ROUTES    = 8,
  parameter int ARPS      = 8,
  parameter int PORTS     = 4,
  localparam int PW       = $clog2(PORTS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inSof,
  input  logic          inEof,
  input  logic [7:0]    inData,
  input  logic [PW-1:0] inPort,
  input  logic          cfgWe,
  input  logic [5:0]    cfgAddr,
  input  logic [47:0]   cfgData,
  output logic          fwdValid,
  output logic          fwdSof,
  output logic          fwdEof,
  output logic [7:0]    fwdData,
  output logic [PW-1:0] fwdPort,
  output logic          slowValid,
  output logic          slowSof,
  output logic          slowEof,
  output logic [7:0]    slowData,
  output logic [PW-1:0] slowPort
);
  fp_strobe_t       st;
  logic [IDX_W-1:0] frameLen;
  logic [31:0]      dstIp;
  logic             routeHit, arpHit;
  logic [PW-1:0]    routePort;
  logic [47:0]      arpMac, portMac;

  fp_control #(.MAX_BYTES(MAX_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .st(st), .frameLen(frameLen)
  );

  fp_tables #(.ROUTES(ROUTES), .ARPS(ARPS), .PORTS(PORTS)) u_tab (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .dstIp(dstIp), .routeHit(routeHit), .routePort(routePort),
    .arpHit(arpHit), .arpMac(arpMac), .portMac(portMac)
  );

  fp_datapath #(.MAX_BYTES(MAX_BYTES), .PW(PW)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .inData(inData), .inPort(inPort), .frameLen(frameLen),
    .dstIp(dstIp), .routeHit(routeHit), .routePort(routePort), .arpHit(arpHit),
    .arpMac(arpMac), .portMac(portMac),
    .fwdValid(fwdValid), .fwdSof(fwdSof), .fwdEof(fwdEof), .fwdData(fwdData), .fwdPort(fwdPort),
    .slowValid(slowValid), .slowSof(slowSof), .slowEof(slowEof), .slowData(slowData), .slowPort(slowPort)
  );
endmodule

// File: rtl/ipv4_fastpath_chk.sv
module ipv4_fastpath_chk #(
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic          inEof,
  input logic          fwdValid,
  input logic          fwdSof,
  input logic [PW-1:0] fwdPort,
  input logic          slowValid,
  input logic          slowSof,
  input logic [PW-1:0] slowPort
);
  logic       armed;
  logic [4:0] lat;
  logic       outStart;

  assign outStart = (fwdValid && fwdSof) || (slowValid && slowSof);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
      lat   <= '0;
    end else if (inValid && inEof) begin
      armed <= 1'b1;
      lat   <= '0;
    end else if (outStart) begin
      armed <= 1'b0;
    end else if (armed && lat != 5'd31) begin
      lat <= lat + 1'b1;
    end
  end

  p_excl_out_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fwdValid, slowValid}));

  p_decide_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    outStart |-> (armed && lat <= 5'd16));

  p_fwd_port_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !fwdSof) |-> $stable(fwdPort));

  p_slow_port_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (slowValid && !slowSof) |-> $stable(slowPort));

  p_fwd_burst_r12: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid && !fwdSof) |-> $past(fwdValid));

  p_slow_burst_r12: assert property (@(posedge clk) disable iff (!rstN)
    (slowValid && !slowSof) |-> $past(slowValid));

  p_quiet_input_r12: assert property (@(posedge clk) disable iff (!rstN)
    (fwdValid || slowValid) |-> !inValid);
endmodule

bind ipv4_fastpath ipv4_fastpath_chk #(.PW(PW)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inEof(inEof),
  .fwdValid(fwdValid), .fwdSof(fwdSof), .fwdPort(fwdPort),
  .slowValid(slowValid), .slowSof(slowSof), .slowPort(slowPort)
);

// File: tb/tb_ipv4_fastpath.sv
module tb_ipv4_fastpath;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, inValid, inSof, inEof, cfgWe;
  logic [7:0] inData;
  logic [1:0] inPort;
  logic [5:0] cfgAddr;
  logic [47:0] cfgData;
  logic fwdValid, fwdSof, fwdEof, slowValid, slowSof, slowEof;
  logic [7:0] fwdData, slowData;
  logic [1:0] fwdPort, slowPort;

  ipv4_fastpath dut (.*);

  int total = 0, bad = 0;
  bit finished = 0;
  logic [12:0] expQ[$];
  string tagQ[$];
  byte unsigned frm[64];
  int flen;

  localparam logic [47:0] MAC_A = 48'h00005E000001;
  localparam logic [47:0] MAC_B = 48'h00005E000002;

  function automatic logic [47:0] pmac(input int p);
    return 48'h02AA00000000 + 48'(p);
  endfunction

  function automatic logic [15:0] ipSum(input byte unsigned a[64]);
    logic [31:0] s = 0;
    for (int w = 0; w < 10; w++)
      if (w != 5) s += {a[14 + 2*w], a[15 + 2*w]};
    s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
    return ~s[15:0];
  endfunction

  task automatic fixCs();
    logic [15:0] c = ipSum(frm);
    frm[24] = c[15:8]; frm[25] = c[7:0];
  endtask

  task automatic buildIp(input logic [31:0] dst, input logic [7:0] ttl);
    for (int i = 0; i < 64; i++) frm[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 6; i++) begin frm[i] = 8'hC0 + 8'(i); frm[6+i] = 8'hD0 + 8'(i); end
    frm[12] = 8'h08; frm[13] = 8'h00; frm[14] = 8'h45; frm[15] = 8'h00;
    frm[16] = 8'h00; frm[17] = 8'd26; frm[18] = 8'h12; frm[19] = 8'h34;
    frm[20] = 8'h00; frm[21] = 8'h00; frm[22] = ttl; frm[23] = 8'd17;
    frm[26] = 8'd192; frm[27] = 8'd168; frm[28] = 8'd0; frm[29] = 8'd5;
    {frm[30], frm[31], frm[32], frm[33]} = dst;
    flen = 40;
    fixCs();
  endtask

  task automatic cfgWrite(input logic [5:0] a, input logic [47:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic sendFrame(input int port, input bit expFwd, input int expPort,
                           input logic [47:0] dmac, input string tag);
    byte unsigned e[64];
    logic [15:0] c;
    e = frm;
    if (expFwd) begin
      for (int i = 0; i < 6; i++) begin
        e[i]   = dmac[47 - 8*i -: 8];
        e[6+i] = pmac(expPort)[47 - 8*i -: 8];
      end
      e[22] = e[22] - 8'd1;
      c = ipSum(e); e[24] = c[15:8]; e[25] = c[7:0];
    end
    for (int i = 0; i < flen; i++) begin
      expQ.push_back({~expFwd, expFwd ? 2'(expPort) : 2'(port), i == 0, i == flen - 1, e[i]});
      tagQ.push_back(tag);
    end
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      inValid = 1'b1; inSof = (i == 0); inEof = (i == flen - 1);
      inData = frm[i]; inPort = 2'(port);
    end
    @(negedge clk); inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    repeat (flen + 30) @(negedge clk);
  endtask

  logic [12:0] got, expv;
  string tg;
  initial forever begin
    @(negedge clk);
    if (rstN && (fwdValid || slowValid)) begin
      got = slowValid ? {1'b1, slowPort, slowSof, slowEof, slowData}
                      : {1'b0, fwdPort, fwdSof, fwdEof, fwdData};
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R12 unexpected output byte got=%h exp=none", got);
      end else begin
        expv = expQ.pop_front(); tg = tagQ.pop_front();
        if (got !== expv) begin
          bad++;
          $display("FAIL %s got=%h exp=%h", tg, got, expv);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1; total++; bad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 0; inValid = 0; inSof = 0; inEof = 0; inData = 0; inPort = 0;
    cfgWe = 0; cfgAddr = 0; cfgData = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    total++;
    if (fwdValid !== 1'b0 || slowValid !== 1'b0) begin
      bad++; $display("FAIL R11 reset outputs got=%b%b exp=00", fwdValid, slowValid);
    end

    // R9: route 0 = 10/8 via 192.168.1.1 on port 1
    cfgWrite({3'd0, 3'd0}, 48'h0A000000); cfgWrite({3'd1, 3'd0}, 48'hFF000000);
    cfgWrite({3'd2, 3'd0}, 48'hC0A80101); cfgWrite({3'd3, 3'd0}, 48'h5);
    // route 1 = 10.1/16 direct on port 2
    cfgWrite({3'd0, 3'd1}, 48'h0A010000); cfgWrite({3'd1, 3'd1}, 48'hFFFF0000);
    cfgWrite({3'd2, 3'd1}, 48'h0);        cfgWrite({3'd3, 3'd1}, 48'h6);
    // route 2 = 172.16/12 via 192.168.9.9 on port 3 (no cache entry)
    cfgWrite({3'd0, 3'd2}, 48'hAC100000); cfgWrite({3'd1, 3'd2}, 48'hFFF00000);
    cfgWrite({3'd2, 3'd2}, 48'hC0A80909); cfgWrite({3'd3, 3'd2}, 48'h7);
    cfgWrite({3'd4, 3'd0}, 48'h1C0A80101); cfgWrite({3'd5, 3'd0}, MAC_A);
    cfgWrite({3'd4, 3'd3}, 48'h10A010203); cfgWrite({3'd5, 3'd3}, MAC_B);
    for (int p = 0; p < 4; p++) cfgWrite({3'd6, 3'(p)}, pmac(p));

    buildIp(32'h0A050505, 8'd64);  sendFrame(0, 1, 1, MAC_A, "R1 R8 forward via next hop");
    buildIp(32'h0A010203, 8'd10);  sendFrame(3, 1, 2, MAC_B, "R5 R6 longest prefix direct");
    buildIp(32'h0A010909, 8'd10);  sendFrame(2, 0, 0, 0, "R7 cache miss direct");
    buildIp(32'hAC100303, 8'd10);  sendFrame(1, 0, 0, 0, "R7 cache miss next hop");
    buildIp(32'h08080808, 8'd64);  sendFrame(3, 0, 0, 0, "R7 route miss");
    buildIp(32'h0A050505, 8'd64); frm[12] = 8'h08; frm[13] = 8'h06;
    sendFrame(1, 0, 0, 0, "R2 address resolution frame");
    buildIp(32'h0A050505, 8'd64); frm[25] = frm[25] ^ 8'h01;
    sendFrame(0, 0, 0, 0, "R3 bad checksum");
    buildIp(32'h0A050505, 8'd64); frm[14] = 8'h46; fixCs();
    sendFrame(2, 0, 0, 0, "R3 header length six");
    buildIp(32'h0A050505, 8'd64); frm[14] = 8'h65; fixCs();
    sendFrame(2, 0, 0, 0, "R3 wrong version");
    buildIp(32'h0A050505, 8'd64); frm[17] = 8'd27; fixCs();
    sendFrame(1, 0, 0, 0, "R3 length mismatch");
    buildIp(32'h0A050505, 8'd64); flen = 20;
    sendFrame(3, 0, 0, 0, "R3 short frame");
    buildIp(32'h0A050505, 8'd1);   sendFrame(0, 0, 0, 0, "R4 ttl one");
    buildIp(32'h0A050505, 8'd0);   sendFrame(1, 0, 0, 0, "R4 ttl zero");
    buildIp(32'h0A050505, 8'd2);   sendFrame(2, 1, 1, MAC_A, "R4 ttl two forwards");
    buildIp(32'h0A0505FF, 8'd255); sendFrame(3, 1, 1, MAC_A, "R1 ttl 255 checksum");
    cfgWrite({3'd3, 3'd1}, 48'h2);
    buildIp(32'h0A010203, 8'd33);  sendFrame(0, 1, 1, MAC_A, "R9 invalidated route falls back");

    total++;
    if (expQ.size() != 0) begin
      bad++; $display("FAIL R12 missing output bytes got=%0d exp=0", expQ.size());
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule